// File: doc/BRIEF.md
# Two-Channel Serial Register Port

This block is the host-facing register file of a two-channel asynchronous serial controller. A byte-wide bus reaches it through two address bits. Bit 0 chooses between the control port (0) and the data port (1). Bit 1 chooses the channel: 0 is channel A and 1 is channel B. Each channel has its own copy of the registers.

Control-port traffic goes through a 4-bit register index that normally rests at 0. A control write made while the index is 0 loads a new index. The next control access then reaches the indexed register, and the index falls back to 0 afterwards. A write to index 9 with a nonzero reset code resets one or both channels.

From the stored fields the block decodes the line settings of each channel: parity, stop bits, character length, transmitter enable, total clock divisor and resulting baud rate. A bit shifter outside the block uses these settings. The data port hands received bytes to the host. The receive side offers a simple valid/ready input, and each channel holds one byte.

Top module: `ser_port_regs`

## Requirements
- R1: While the index is 0, a control write sets the index to wdata[2:0]. If wdata[5:3] is 3'b001 it adds 8 to that value. Any other command code in wdata[5:3] leaves the index in 0..7.
- R2: A control write made while the index is nonzero stores its byte into the indexed register and returns the index to 0. Every control read returns the index to 0.
- R3: Writing index 9 with wdata[7:6] = 2'b01 resets channel B, 2'b10 resets channel A and 2'b11 resets both. The writing channel's index returns to 0. A code of 2'b00 resets nothing.
- R4: After reset, status (read index 0) is 0x44, read index 1 is 0x07, parity is off, there is one stop bit, the clock divide is x1, the length is 5 bits, the transmitter is off, the receiver is off and the time constant is 0.
- R5: In register 4, bit 0 enables parity and bit 1 selects even parity. Bits [3:2] = 2'b11 select two stop bits; any other value selects one. Bits [7:6] select a clock divide of 1, 16, 32 or 64.
- R6: In register 5, bits [6:5] set the character length: 00 = 5, 01 = 7, 10 = 6, 11 = 8. Bit 3 enables the transmitter.
- R7: The 16-bit time constant is {register 13, register 12}. baud_div = 2 × (time constant + 2) × clock divide, and baud_rate = CLK_HZ / baud_div, rounded down.
- R8: Control reads at index 12 and 13 return the bytes written there. Control reads at indices 2–11, 14 and 15 return 0.
- R9: A data-port write leaves status bit 2 (Tx empty) and read-index-1 bit 0 (all sent) set.
- R10: A data-port read returns the last accepted receive byte and clears status bit 0 (Rx available).
- R11: rx_ready is high only when register 3 bit 0 is set and status bit 0 is clear. A byte offered while rx_ready is low is dropped, and the held byte is kept.
- R12: The two channels are independent. An access to one channel changes no register, index or output of the other, except through an R3 reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of both channels |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 2 | [0]: 0 control, 1 data; [1]: 0 channel A, 1 channel B |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during the read cycle |
| rx_valid | input | 2 | Per-channel receive byte offered |
| rx_data | input | 2x8 | Per-channel receive byte |
| rx_ready | output | 2 | Per-channel receive byte will be accepted |
| parity_en | output | 2 | Parity enabled |
| parity_even | output | 2 | Even parity selected |
| two_stop | output | 2 | Two stop bits |
| char_bits | output | 2x4 | Character length, 5 to 8 |
| tx_enable | output | 2 | Transmitter enabled |
| baud_div | output | 2x24 | Input clocks per bit |
| baud_rate | output | 2x32 | Bits per second |

## Verification
The bench uses the command field to reach indices above 7. It checks that a different command code keeps the index low, so a design that always added 8 would put the data into the time constant. It reads status right after a register access and after a reset command. A design that left the index parked would then return register contents in place of 0x44. The bench sends each reset code from the opposite channel, so a swapped channel mapping shows up as the wrong channel returning to defaults. It also offers bytes while the receiver is disabled and while a byte is already held. A design that overwrote the held byte would return the later value on the data read.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;

    localparam int NCH    = 2;
    localparam int PTR_W  = 4;
    localparam int TC_W   = 16;
    localparam int MODE_W = 7;
    localparam int DIV_W  = TC_W + MODE_W + 1;
    localparam int RATE_W = 32;

    localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

    localparam logic [PTR_W-1:0] IDX_STATUS = 4'd0;
    localparam logic [PTR_W-1:0] IDX_SPEC   = 4'd1;
    localparam logic [PTR_W-1:0] IDX_RXCFG  = 4'd3;
    localparam logic [PTR_W-1:0] IDX_LINE   = 4'd4;
    localparam logic [PTR_W-1:0] IDX_TXCFG  = 4'd5;
    localparam logic [PTR_W-1:0] IDX_RESET  = 4'd9;
    localparam logic [PTR_W-1:0] IDX_TC_LO  = 4'd12;
    localparam logic [PTR_W-1:0] IDX_TC_HI  = 4'd13;

    // Reset request code carried in bits [7:6] of an index-9 write
    typedef enum logic [1:0] {
        SRST_NONE = 2'b00,
        SRST_B    = 2'b01,
        SRST_A    = 2'b10,
        SRST_BOTH = 2'b11
    } srst_code_t;

    typedef struct packed {
        logic [1:0]      par_ctl;   // [0] enable, [1] even
        logic [1:0]      stop_ctl;  // 2'b11 = two stop bits
        logic [1:0]      clk_mode;  // divide selector
        logic [1:0]      len_code;  // character length code
        logic            tx_en;
        logic [TC_W-1:0] tconst;
    } chan_cfg_t;

    function automatic logic [MODE_W-1:0] clk_div_of(input logic [1:0] mode);
        case (mode)
            2'b00:   return MODE_W'(1);
            2'b01:   return MODE_W'(16);
            2'b10:   return MODE_W'(32);
            default: return MODE_W'(64);
        endcase
    endfunction

    function automatic logic [3:0] char_len_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd5;
            2'b01:   return 4'd7;
            2'b10:   return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/ser_line_decode.sv
module ser_line_decode
    import ser_regs_pkg::*;
#(
    parameter int unsigned CLK_HZ = 7_372_800
) (
    input  chan_cfg_t          cfg,
    output logic               parity_en,
    output logic               parity_even,
    output logic               two_stop,
    output logic [3:0]         char_bits,
    output logic               tx_enable,
    output logic [DIV_W-1:0]   baud_div,
    output logic [RATE_W-1:0]  baud_rate
);
    logic [DIV_W-1:0] tc_plus;
    logic [DIV_W-1:0] mode_div;

    always_comb begin
        parity_en   = cfg.par_ctl[0];
        parity_even = cfg.par_ctl[1];
        two_stop    = (cfg.stop_ctl == 2'b11);
        char_bits   = char_len_of(cfg.len_code);
        tx_enable   = cfg.tx_en;
        tc_plus     = DIV_W'(cfg.tconst) + DIV_W'(2);
        mode_div    = DIV_W'(clk_div_of(cfg.clk_mode));
        baud_div    = (tc_plus * mode_div) << 1;
        baud_rate   = RATE_W'(CLK_HZ) / RATE_W'(baud_div);
    end

endmodule

// File: rtl/ser_chan_regs.sv
module ser_chan_regs
    import ser_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic             is_data,
    input  logic [7:0]       wdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic [7:0]       rdata,
    output logic [1:0]       srst_req,
    output chan_cfg_t        cfg,
    output logic             rx_ready,
    output logic [PTR_W-1:0] ptr
);
    logic       rx_en_q;
    logic       rxav_q;
    logic       txempty_q;
    logic       allsent_q;
    logic [7:0] rxbuf_q;

    logic ctrl_wr;
    logic ctrl_rd;

    assign ctrl_wr  = wr && !is_data;
    assign ctrl_rd  = rd && !is_data;
    assign rx_ready = rx_en_q && !rxav_q;
    assign srst_req = (ctrl_wr && ptr == IDX_RESET) ? wdata[7:6] : SRST_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr          <= '0;
            cfg.par_ctl  <= 2'b00;
            cfg.stop_ctl <= 2'b01;
            cfg.clk_mode <= 2'b00;
            cfg.len_code <= 2'b00;
            cfg.tx_en    <= 1'b0;
            cfg.tconst   <= '0;
            rx_en_q      <= 1'b0;
            rxav_q       <= 1'b0;
            txempty_q    <= 1'b1;
            allsent_q    <= 1'b1;
            rxbuf_q      <= '0;
        end else begin
            if (ctrl_wr) begin
                if (ptr == IDX_STATUS) begin
                    ptr <= {wdata[5:3] == CMD_POINT_HIGH, wdata[2:0]};
                end else begin
                    ptr <= '0;
                    case (ptr)
                        IDX_RXCFG: rx_en_q <= wdata[0];
                        IDX_LINE: begin
                            cfg.par_ctl  <= wdata[1:0];
                            cfg.stop_ctl <= wdata[3:2];
                            cfg.clk_mode <= wdata[7:6];
                        end
                        IDX_TXCFG: begin
                            cfg.len_code <= wdata[6:5];
                            cfg.tx_en    <= wdata[3];
                        end
                        IDX_TC_LO: cfg.tconst[7:0]  <= wdata;
                        IDX_TC_HI: cfg.tconst[15:8] <= wdata;
                        default: ;
                    endcase
                end
            end else if (ctrl_rd) begin
                ptr <= '0;
            end
            if (wr && is_data) begin
                txempty_q <= 1'b1;
                allsent_q <= 1'b1;
            end
            if (rd && is_data) begin
                rxav_q <= 1'b0;
            end
            if (rx_valid && rx_ready) begin
                rxav_q  <= 1'b1;
                rxbuf_q <= rx_data;
            end
        end
    end

    always_comb begin
        if (is_data) begin
            rdata = rxbuf_q;
        end else begin
            case (ptr)
                IDX_STATUS: rdata = {1'b0, 1'b1, 3'b000, txempty_q, 1'b0, rxav_q};
                IDX_SPEC:   rdata = {5'b00000, 2'b11, allsent_q};
                IDX_TC_LO:  rdata = cfg.tconst[7:0];
                IDX_TC_HI:  rdata = cfg.tconst[15:8];
                default:    rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/ser_port_regs.sv
module ser_port_regs
    import ser_regs_pkg::*;
#(
    parameter int unsigned CLK_HZ = 7_372_800
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [1:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic [1:0]                  rx_valid,
    input  logic [1:0][7:0]             rx_data,
    output logic [1:0]                  rx_ready,
    output logic [1:0]                  parity_en,
    output logic [1:0]                  parity_even,
    output logic [1:0]                  two_stop,
    output logic [1:0][3:0]             char_bits,
    output logic [1:0]                  tx_enable,
    output logic [1:0][DIV_W-1:0]       baud_div,
    output logic [1:0][RATE_W-1:0]      baud_rate
);
    localparam int CH_A = 0;
    localparam int CH_B = 1;

    logic [NCH-1:0][7:0]       ch_rdata;
    logic [NCH-1:0][1:0]       ch_srst;
    logic [NCH-1:0]            ch_rst;
    logic [NCH-1:0][PTR_W-1:0] ptr_view;
    chan_cfg_t                 ch_cfg [NCH];

    // Reset request bit 1 targets channel A, bit 0 targets channel B
    always_comb begin
        ch_rst = {NCH{rst}};
        for (int c = 0; c < NCH; c++) begin
            ch_rst[CH_A] = ch_rst[CH_A] | ch_srst[c][1];
            ch_rst[CH_B] = ch_rst[CH_B] | ch_srst[c][0];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (bus_addr[1] == 1'(c));

        ser_chan_regs u_regs (
            .clk      (clk),
            .rst      (ch_rst[c]),
            .wr       (bus_wr && sel),
            .rd       (bus_rd && sel),
            .is_data  (bus_addr[0]),
            .wdata    (bus_wdata),
            .rx_valid (rx_valid[c]),
            .rx_data  (rx_data[c]),
            .rdata    (ch_rdata[c]),
            .srst_req (ch_srst[c]),
            .cfg      (ch_cfg[c]),
            .rx_ready (rx_ready[c]),
            .ptr      (ptr_view[c])
        );

        ser_line_decode #(.CLK_HZ(CLK_HZ)) u_dec (
            .cfg         (ch_cfg[c]),
            .parity_en   (parity_en[c]),
            .parity_even (parity_even[c]),
            .two_stop    (two_stop[c]),
            .char_bits   (char_bits[c]),
            .tx_enable   (tx_enable[c]),
            .baud_div    (baud_div[c]),
            .baud_rate   (baud_rate[c])
        );
    end

    assign bus_rdata = ch_rdata[bus_addr[1]];

endmodule

// File: rtl/ser_port_regs_chk.sv
module ser_port_regs_chk
    import ser_regs_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [1:0]                  bus_addr,
    input logic [7:0]                  bus_wdata,
    input logic [1:0]                  rx_valid,
    input logic [1:0]                  rx_ready,
    input logic [1:0][3:0]             char_bits,
    input logic [1:0][DIV_W-1:0]       baud_div,
    input logic [NCH-1:0][PTR_W-1:0]   ptr_view
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic ctl_wr;
        logic ctl_rd;
        assign ctl_wr = bus_wr && !bus_addr[0] && (bus_addr[1] == 1'(c));
        assign ctl_rd = bus_rd && !bus_addr[0] && (bus_addr[1] == 1'(c));

        // R1: point-high command lands in the upper half of the index space
        a_r1_point_high: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && ptr_view[c] == '0 && bus_wdata[5:3] == 3'b001) |=> ptr_view[c][3]);

        // R1: other command codes keep the index in the lower half
        a_r1_point_low: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && ptr_view[c] == '0 && bus_wdata[5:3] != 3'b001) |=> !ptr_view[c][3]);

        // R2: access to a selected register parks the index again
        a_r2_write_parks: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && ptr_view[c] != '0) |=> ptr_view[c] == '0);

        a_r2_read_parks: assert property (@(posedge clk) disable iff (rst)
            ctl_rd |=> ptr_view[c] == '0);

        // R11: an accepted byte blocks further bytes until read
        a_r11_hold_byte: assert property (@(posedge clk) disable iff (rst)
            (rx_valid[c] && rx_ready[c]) |=> !rx_ready[c]);

        // R6: length is always one of the four legal values
        a_r6_len_legal: assert property (@(posedge clk) disable iff (rst)
            (char_bits[c] >= 4'd5 && char_bits[c] <= 4'd8));
    end

    // R3: reset-both code returns both channels to default divisor and length
    a_r3_reset_both: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0] && ptr_view[bus_addr[1]] == 4'd9 && bus_wdata[7:6] == 2'b11)
        |=> (baud_div[0] == DIV_W'(4) && baud_div[1] == DIV_W'(4)
             && char_bits[0] == 4'd5 && char_bits[1] == 4'd5));

endmodule

bind ser_port_regs ser_port_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .char_bits (char_bits),
    .baud_div  (baud_div),
    .ptr_view  (ptr_view)
);

// File: tb/tb_ser_port_regs.sv
module tb_ser_port_regs;
    localparam int unsigned CLK_HZ = 7_372_800;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [1:0]       rx_valid = '0;
    logic [1:0][7:0]  rx_data = '0;
    logic [1:0]       rx_ready;
    logic [1:0]       parity_en;
    logic [1:0]       parity_even;
    logic [1:0]       two_stop;
    logic [1:0][3:0]  char_bits;
    logic [1:0]       tx_enable;
    logic [1:0][23:0] baud_div;
    logic [1:0][31:0] baud_rate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    ser_port_regs #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .parity_en(parity_en), .parity_even(parity_even), .two_stop(two_stop),
        .char_bits(char_bits), .tx_enable(tx_enable),
        .baud_div(baud_div), .baud_rate(baud_rate)
    );

    // Monitor: every read cycle pops one expected byte, sampled mid-cycle
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s read: got 0x%02h expected 0x%02h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_op(input bit is_wr, input int ch, input bit dat, input logic [7:0] v);
        bus_wr    = is_wr;
        bus_rd    = !is_wr;
        bus_addr  = {ch[0], dat};
        bus_wdata = v;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic sel_idx(input int ch, input int idx);
        if (idx >= 8) bus_op(1, ch, 0, 8'h08 | 8'(idx - 8));
        else if (idx != 0) bus_op(1, ch, 0, 8'(idx));
    endtask

    task automatic wr_reg(input int ch, input int idx, input logic [7:0] v);
        sel_idx(ch, idx);
        bus_op(1, ch, 0, v);
    endtask

    task automatic rd_reg(input int ch, input int idx, input logic [7:0] e, input string t);
        sel_idx(ch, idx);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_op(0, ch, 0, 8'h00);
    endtask

    task automatic rd_data(input int ch, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_op(0, ch, 1, 8'h00);
    endtask

    task automatic rx_push(input int ch, input logic [7:0] v);
        rx_valid[ch] = 1'b1;
        rx_data[ch]  = v;
        @(posedge clk);
        #1;
        rx_valid[ch] = 1'b0;
    endtask

    task automatic chk(input string t, input longint act, input longint e);
        checks++;
        if (act != e) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", t, act, e);
        end
    endtask

    function automatic int mode_div(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 16 : (m == 2'd2) ? 32 : 64;
    endfunction

    // R7 reference: divisor and rate from time constant and divide selector
    task automatic chk_line(input string t, input int ch, input int tc, input logic [1:0] m,
                            input bit pe, input bit pv, input bit ts, input int cb, input bit te);
        longint d;
        longint r;
        d = 2 * (tc + 2) * mode_div(m);
        r = ((CLK_HZ / 2) / (tc + 2)) / mode_div(m);
        chk({t, " R7 baud_div"}, baud_div[ch], d);
        chk({t, " R7 baud_rate"}, baud_rate[ch], r);
        chk({t, " R5 parity_en"}, parity_en[ch], pe);
        chk({t, " R5 parity_even"}, parity_even[ch], pv);
        chk({t, " R5 two_stop"}, two_stop[ch], ts);
        chk({t, " R6 char_bits"}, char_bits[ch], cb);
        chk({t, " R6 tx_enable"}, tx_enable[ch], te);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R4 reset state on both channels
        for (int c = 0; c < 2; c++) begin
            chk_line("R4 reset", c, 0, 2'd0, 0, 0, 0, 5, 0);
            chk("R4 rx_ready", rx_ready[c], 0);
            rd_reg(c, 0, 8'h44, "R4 status");
            rd_reg(c, 1, 8'h07, "R4 spec");
        end

        // R5 R6 R7: parity even, two stop, x16, 8 bits, tx on, tc 0x010A
        wr_reg(0, 4, 8'h4F);
        wr_reg(0, 5, 8'h68);
        wr_reg(0, 12, 8'h0A);
        wr_reg(0, 13, 8'h01);
        chk_line("cfg1", 0, 266, 2'd1, 1, 1, 1, 8, 1);
        chk_line("R12 other channel", 1, 0, 2'd0, 0, 0, 0, 5, 0);
        rd_reg(1, 12, 8'h00, "R12 ch B tc_lo");

        // R8 read-back and unused index
        rd_reg(0, 12, 8'h0A, "R8 tc_lo");
        rd_reg(0, 13, 8'h01, "R8 tc_hi");
        rd_reg(0, 2, 8'h00, "R8 idx2");
        rd_reg(0, 15, 8'h00, "R8 idx15");
        // R2: after a read the index is parked
        rd_reg(0, 0, 8'h44, "R2 after read");

        // R1: a non point-high command keeps index 4, not 12
        bus_op(1, 0, 0, 8'h14);
        bus_op(1, 0, 0, 8'h81);
        chk_line("R1 cmd010 cfg", 0, 266, 2'd2, 1, 0, 0, 8, 1);
        rd_reg(0, 12, 8'h0A, "R1 tc_lo untouched");
        // R2: after a write the index is parked
        rd_reg(0, 0, 8'h44, "R2 after write");

        // R5 1.5-stop code is one stop, x64; R6 7 and 6 bits
        wr_reg(0, 4, 8'hC8);
        wr_reg(0, 5, 8'h20);
        chk_line("cfg2", 0, 266, 2'd3, 0, 0, 0, 7, 0);
        wr_reg(0, 5, 8'h40);
        chk("R6 six bits", char_bits[0], 6);

        // R11: receiver disabled drops bytes
        rx_push(0, 8'h5A);
        rd_reg(0, 0, 8'h44, "R11 disabled drop");
        wr_reg(0, 3, 8'h01);
        chk("R11 ready enabled", rx_ready[0], 1);
        rx_push(0, 8'hA5);
        chk("R11 ready when full", rx_ready[0], 0);
        rd_reg(0, 0, 8'h45, "R10 rx available");
        rx_push(0, 8'h33);
        rd_data(0, 8'hA5, "R11 held byte kept / R10 data");
        rd_reg(0, 0, 8'h44, "R10 rx cleared");
        chk("R11 ready again", rx_ready[0], 1);

        // R9 data write keeps tx-empty and all-sent
        bus_op(1, 0, 1, 8'h77);
        rd_reg(0, 0, 8'h44, "R9 status");
        rd_reg(0, 1, 8'h07, "R9 spec");

        // R3: index-9 code 00 resets nothing
        wr_reg(0, 9, 8'h00);
        chk("R3 code00 keeps cfg", char_bits[0], 6);

        // R3: channel A resets B, A keeps state, A index parked
        rx_push(0, 8'h3C);
        wr_reg(1, 4, 8'hC1);
        chk("R3 ch B cfg set", parity_en[1], 1);
        wr_reg(0, 9, 8'h40);
        chk_line("R3 reset B", 1, 0, 2'd0, 0, 0, 0, 5, 0);
        rd_reg(0, 0, 8'h45, "R3 A untouched, index parked");
        chk("R3 A divisor kept", baud_div[0], 2 * 268 * 64);

        // R3: channel B resets A
        wr_reg(1, 4, 8'h01);
        wr_reg(1, 9, 8'h80);
        chk_line("R3 reset A", 0, 0, 2'd0, 0, 0, 0, 5, 0);
        chk("R3 A rx off", rx_ready[0], 0);
        rd_reg(0, 0, 8'h44, "R3 A status");
        chk("R3 B kept", parity_en[1], 1);

        // R3: reset both
        wr_reg(0, 4, 8'h03);
        wr_reg(0, 9, 8'hC0);
        chk("R3 both A", parity_en[0], 0);
        chk("R3 both B", parity_en[1], 0);
        rd_reg(1, 12, 8'h00, "R3 both B tc");

        repeat (2) @(posedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule